// File: doc/BRIEF.md
# Descriptor Chain Walker (Transmit)

This block walks a linked list of buffer descriptors held in memory for the transmit direction. Each descriptor is a 64-byte record stored little-endian. It holds a next pointer, a 64-bit buffer address, a control word with the length and frame markers, a status word, and five application words. The walker fetches each descriptor through a word-wide memory port and hands the buffer address and length to a data mover. It then writes the status word back and follows the next pointer. It stops once the descriptor it has just processed is the one at the tail pointer.

The register block sends a start pulse after software updates the tail pointer. With that pulse it supplies the current and tail pointers and the channel's run and idle flags. The walker returns the updated current pointer, plus one-cycle pulses for halt, idle, frame start and frame completion, and an error pulse. The error pulse fires when a frame would grow past the permitted length.

Top module: `dcw_walker`

## Requirements
- R1: A walk begins only on a cycle where start_i, run_i and !idle_i are all high; a start pulse given while run_i is low or idle_i is high produces no memory request.
- R2: Only one memory request is outstanding at a time; mem_req_o stays high with a stable address and write flag until mem_rsp_i is seen.
- R3: If the fetched status word (byte offset 28) already has bit 31 set, halt_o pulses, no write-back or transfer occurs, and the walk stops.
- R4: For each accepted descriptor, xfer_valid_o pulses once with xfer_addr_o equal to the 64-bit buffer address (low word at offset 8, high word at offset 12) and xfer_len_o equal to control bits 22:0 (control at offset 24).
- R5: When control bit 27 (start of frame) is set, frame_start_o and app_valid_o pulse with the transfer, app_o carries the five words from offsets 32..48 (word k in bits 32k+31:32k), and the accumulated frame length restarts from zero.
- R6: When control bit 26 (end of frame) is set, frame_done_o pulses with the transfer and the accumulated frame length returns to zero.
- R7: After each transfer, the walker writes the status word at descriptor offset 28 as the length with bit 31 set, and the other bits clear.
- R8: After the write-back, cur_ptr_we_o pulses with cur_ptr_o equal to the next pointer (offset 0). If the descriptor just processed was at tail_ptr_i, idle_o pulses in that same cycle and the walk stops; otherwise the next descriptor is fetched.
- R9: If the accumulated frame length including the current descriptor would exceed MAX_FRAME (16384) bytes, err_o pulses, and no transfer or write-back happens for that descriptor. The walk stops and the accumulated length is cleared. A frame of exactly MAX_FRAME bytes is accepted.
- R10: After reset, all pulses and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse from the register block |
| run_i | input | 1 | Channel running |
| idle_i | input | 1 | Channel idle |
| cur_ptr_i | input | AW | Descriptor address to start from |
| tail_ptr_i | input | AW | Tail descriptor address |
| cur_ptr_o | output | AW | Updated current pointer |
| cur_ptr_we_o | output | 1 | Current pointer update strobe |
| halt_o | output | 1 | Pulse: halted on a completed descriptor |
| idle_o | output | 1 | Pulse: tail reached |
| err_o | output | 1 | Pulse: frame length overflow |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rsp_i | input | 1 | Request accepted and completed |
| mem_rdata_i | input | 32 | Read data, valid with mem_rsp_i |
| xfer_valid_o | output | 1 | Transfer command pulse |
| xfer_addr_o | output | 64 | Buffer address |
| xfer_len_o | output | LEN_W | Buffer length in bytes |
| frame_start_o | output | 1 | Pulse: start of frame |
| frame_done_o | output | 1 | Pulse: frame completed |
| app_valid_o | output | 1 | Application words valid |
| app_o | output | 160 | Five application words |

## Verification
On every cycle, the assertions check the memory handshake: a held request keeps its address and direction. They also check that each write-back is preceded by a transfer and that the idle pulse follows a completed write. Further checks cover that at most one terminating pulse fires, that nothing is requested after a halt or error, and that the frame accumulator stays within bound. The contents of the chain can only be shown by the bench's scenarios. These cover the transfer order and values, the application words, the status words written back to memory, the final pointer, and the exact overflow boundary.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RD, S_CHECK, S_WB, S_ADV} st_e;

  localparam int APP_N      = 5;
  localparam int W_NXT      = 0;
  localparam int W_BUF_LO   = 2;
  localparam int W_BUF_HI   = 3;
  localparam int W_CTRL     = 6;
  localparam int W_STATUS   = 7;
  localparam int W_APP0     = 8;
  localparam int CTRL_EOF   = 26;
  localparam int CTRL_SOF   = 27;
  localparam int STS_DONE   = 31;
  localparam logic [3:0] STEP_NOSOF_LAST = 4'd4;
  localparam logic [3:0] STEP_SOF_LAST   = 4'd9;

  // fetch order: status, control, next, buffer lo/hi, then app words
  function automatic logic [3:0] step_word(input logic [3:0] s);
    case (s)
      4'd0:    step_word = 4'(W_STATUS);
      4'd1:    step_word = 4'(W_CTRL);
      4'd2:    step_word = 4'(W_NXT);
      4'd3:    step_word = 4'(W_BUF_LO);
      4'd4:    step_word = 4'(W_BUF_HI);
      default: step_word = s + 4'd3;
    endcase
  endfunction
endpackage

// File: rtl/dcw_desc_store.sv
module dcw_desc_store
  import dcw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 23
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_i,
  input  logic [3:0]            widx_i,
  input  logic [31:0]           data_i,
  output logic [AW-1:0]         next_o,
  output logic [63:0]           buf_o,
  output logic [LEN_W-1:0]      len_o,
  output logic                  sof_o,
  output logic                  eof_o,
  output logic [APP_N*32-1:0]   app_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_o <= '0;
      buf_o  <= '0;
      len_o  <= '0;
      sof_o  <= 1'b0;
      eof_o  <= 1'b0;
    end else if (cap_i) begin
      case (widx_i)
        4'(W_NXT):    next_o        <= data_i[AW-1:0];
        4'(W_BUF_LO): buf_o[31:0]   <= data_i;
        4'(W_BUF_HI): buf_o[63:32]  <= data_i;
        4'(W_CTRL): begin
          len_o <= data_i[LEN_W-1:0];
          sof_o <= data_i[CTRL_SOF];
          eof_o <= data_i[CTRL_EOF];
        end
        default: ;
      endcase
    end
  end

  for (genvar j = 0; j < APP_N; j++) begin : g_app
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   app_o[32*j +: 32] <= '0;
      else if (cap_i && widx_i == 4'(W_APP0 + j))    app_o[32*j +: 32] <= data_i;
    end
  end
endmodule

// File: rtl/dcw_frame_acc.sv
module dcw_frame_acc #(
  parameter int LEN_W     = 23,
  parameter int MAX_FRAME = 16384
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             commit_i,
  input  logic             clear_i,
  output logic             over_o
);
  localparam int PW = $clog2(MAX_FRAME + 1);
  localparam int SW = (LEN_W > PW ? LEN_W : PW) + 1;

  logic [PW-1:0] pos_q;
  logic [SW-1:0] cand;

  assign cand   = (sof_i ? '0 : SW'(pos_q)) + SW'(len_i);
  assign over_o = cand > SW'(MAX_FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= '0;
    else if (clear_i)  pos_q <= '0;
    else if (commit_i) pos_q <= eof_i ? '0 : cand[PW-1:0];
  end

  a_r9_pos_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= PW'(MAX_FRAME));
  a_r6_eof_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && eof_i && !clear_i |=> pos_q == '0);
endmodule

// File: rtl/dcw_walker.sv
module dcw_walker
  import dcw_pkg::*;
#(
  parameter int AW        = 32,  // pointer width, at most 32
  parameter int LEN_W     = 23,
  parameter int MAX_FRAME = 16384
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 run_i,
  input  logic                 idle_i,
  input  logic [AW-1:0]        cur_ptr_i,
  input  logic [AW-1:0]        tail_ptr_i,
  output logic [AW-1:0]        cur_ptr_o,
  output logic                 cur_ptr_we_o,
  output logic                 halt_o,
  output logic                 idle_o,
  output logic                 err_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [31:0]          mem_wdata_o,
  input  logic                 mem_rsp_i,
  input  logic [31:0]          mem_rdata_i,
  output logic                 xfer_valid_o,
  output logic [63:0]          xfer_addr_o,
  output logic [LEN_W-1:0]     xfer_len_o,
  output logic                 frame_start_o,
  output logic                 frame_done_o,
  output logic                 app_valid_o,
  output logic [APP_N*32-1:0]  app_o
);
  st_e           st_q;
  logic [3:0]    step_q;
  logic [AW-1:0] cur_q;
  logic [AW-1:0] next_w;
  logic [3:0]    widx;
  logic          sof_w, eof_w, over_w, cap_w, last_rd;

  assign widx    = (st_q == S_WB) ? 4'(W_STATUS) : step_word(step_q);
  assign cap_w   = (st_q == S_RD) && mem_rsp_i;
  assign last_rd = sof_w ? (step_q == STEP_SOF_LAST) : (step_q == STEP_NOSOF_LAST);

  dcw_desc_store #(.AW(AW), .LEN_W(LEN_W)) u_store (
    .clk_i, .rst_ni, .cap_i(cap_w), .widx_i(widx), .data_i(mem_rdata_i),
    .next_o(next_w), .buf_o(xfer_addr_o), .len_o(xfer_len_o),
    .sof_o(sof_w), .eof_o(eof_w), .app_o(app_o)
  );

  dcw_frame_acc #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_acc (
    .clk_i, .rst_ni, .sof_i(sof_w), .eof_i(eof_w), .len_i(xfer_len_o),
    .commit_i(xfer_valid_o), .clear_i(err_o), .over_o(over_w)
  );

  assign mem_req_o     = (st_q == S_RD) || (st_q == S_WB);
  assign mem_we_o      = (st_q == S_WB);
  assign mem_addr_o    = cur_q + AW'({widx, 2'b00});
  assign mem_wdata_o   = {1'b1, {(31-LEN_W){1'b0}}, xfer_len_o};

  assign halt_o        = cap_w && (step_q == 4'd0) && mem_rdata_i[STS_DONE];
  assign xfer_valid_o  = (st_q == S_CHECK) && !over_w;
  assign err_o         = (st_q == S_CHECK) && over_w;
  assign frame_start_o = xfer_valid_o && sof_w;
  assign app_valid_o   = xfer_valid_o && sof_w;
  assign frame_done_o  = xfer_valid_o && eof_w;
  assign cur_ptr_we_o  = (st_q == S_ADV);
  assign cur_ptr_o     = next_w;
  assign idle_o        = (st_q == S_ADV) && (cur_q == tail_ptr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      step_q <= '0;
      cur_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i && run_i && !idle_i) begin
          cur_q  <= cur_ptr_i;
          step_q <= '0;
          st_q   <= S_RD;
        end
        S_RD: if (mem_rsp_i) begin
          if (halt_o)       st_q <= S_IDLE;
          else if (step_q > 4'd1 && last_rd) st_q <= S_CHECK;
          else              step_q <= step_q + 4'd1;
        end
        S_CHECK: st_q <= over_w ? S_IDLE : S_WB;
        S_WB:    if (mem_rsp_i) st_q <= S_ADV;
        S_ADV: begin
          cur_q  <= next_w;
          step_q <= '0;
          st_q   <= (cur_q == tail_ptr_i) ? S_IDLE : S_RD;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r3_halt_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> !mem_req_o && !xfer_valid_o);
  a_r9_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !mem_req_o && !cur_ptr_we_o);
  a_r7_wb_after_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !$past(mem_we_o) |-> $past(xfer_valid_o));
  a_r8_idle_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> $past(mem_we_o && mem_rsp_i));
  a_r8_single_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({halt_o, idle_o, err_o}));
endmodule

// File: tb/dcw_walker_bench.sv
module dcw_walker_bench;
  localparam int AW = 32;
  localparam int LW = 23;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 0, run = 0, idle = 0;
  logic [AW-1:0] cur_i = '0, tail_i = '0, cur_o, maddr;
  logic cur_we, halt, idl, err, mreq, mwe, mrsp, xv, fs, fd, av;
  logic [31:0] wdata, rdata;
  logic [63:0] xaddr;
  logic [LW-1:0] xlen;
  logic [159:0] app;

  dcw_walker u_dcw_walker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .run_i(run), .idle_i(idle),
    .cur_ptr_i(cur_i), .tail_ptr_i(tail_i), .cur_ptr_o(cur_o), .cur_ptr_we_o(cur_we),
    .halt_o(halt), .idle_o(idl), .err_o(err), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_rsp_i(mrsp), .mem_rdata_i(rdata),
    .xfer_valid_o(xv), .xfer_addr_o(xaddr), .xfer_len_o(xlen),
    .frame_start_o(fs), .frame_done_o(fd), .app_valid_o(av), .app_o(app)
  );

  // memory model, single writer
  logic [31:0] mem [0:255];
  logic stall_en = 0, stall_q = 0, ld_en = 0;
  logic [7:0] ld_idx = '0;
  logic [31:0] ld_data = '0;
  assign mrsp  = mreq && !stall_q;
  assign rdata = mem[maddr[9:2]];
  always @(posedge clk) begin
    stall_q <= stall_en ? ~stall_q : 1'b0;
    if (ld_en) mem[ld_idx] <= ld_data;
    else if (mreq && mwe && mrsp) mem[maddr[9:2]] <= wdata;
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct { logic [63:0] a; logic [LW-1:0] l; bit s; bit e; int k; } xf_t;
  xf_t xq[$];
  logic [AW-1:0] last_cur = '0;
  int r2_viol = 0;
  logic p_req = 0, p_rsp = 0;
  logic [AW-1:0] p_addr = '0;

  function automatic logic [63:0] buf_of(int k);
    return {32'h0000_00A0 + 32'(k), 32'h1000_0000 + 32'(k) * 32'h1000};
  endfunction

  // monitor: pops expected transfers
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_req && !p_rsp && mreq && maddr != p_addr) r2_viol++;
      p_req = mreq; p_rsp = mrsp; p_addr = maddr;
      if (cur_we) last_cur = cur_o;
      if (xv) begin
        if (xq.size() == 0) chk(0, "R4 unexpected xfer", xaddr, 0);
        else begin
          xf_t e;
          e = xq.pop_front();
          chk(xaddr == e.a, "R4 xfer addr", xaddr, e.a);
          chk(64'(xlen) == 64'(e.l), "R4 xfer len", 64'(xlen), 64'(e.l));
          chk(fs == e.s && av == e.s, "R5 frame start", {62'd0, fs, av}, {62'd0, e.s, e.s});
          chk(fd == e.e, "R6 frame done", 64'(fd), 64'(e.e));
          if (e.s) for (int j = 0; j < 5; j++)
            chk(app[32*j +: 32] == 32'hA000_0000 + 32'(e.k*16 + j), "R5 app word",
                64'(app[32*j +: 32]), 64'(32'hA000_0000 + 32'(e.k*16 + j)));
        end
      end
    end
  end

  task automatic poke(input int idx, input logic [31:0] d);
    @(negedge clk); ld_en = 1; ld_idx = 8'(idx); ld_data = d;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic put_desc(input int k, input int nk, input int len, input bit s,
                          input bit e, input bit done);
    logic [63:0] b;
    b = buf_of(k);
    poke(16*k + 0, 32'(nk * 64));
    poke(16*k + 1, 0);
    poke(16*k + 2, b[31:0]);
    poke(16*k + 3, b[63:32]);
    poke(16*k + 6, {4'd0, s, e, 3'd0, 23'(len)});
    poke(16*k + 7, done ? 32'h8000_0005 : 32'h0);
    for (int j = 0; j < 5; j++) poke(16*k + 8 + j, 32'hA000_0000 + 32'(k*16 + j));
  endtask

  task automatic expect_xf(input int k, input int len, input bit s, input bit e);
    xf_t x;
    x.a = buf_of(k); x.l = LW'(len); x.s = s; x.e = e; x.k = k;
    xq.push_back(x);
  endtask

  // returns 1 halt, 2 idle, 3 error, 0 timeout
  task automatic run_walk(input int k0, input int kt, output int kind);
    kind = 0;
    @(negedge clk); cur_i = AW'(k0*64); tail_i = AW'(kt*64); start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 2000 && kind == 0; c++) begin
      if (halt) kind = 1; else if (idl) kind = 2; else if (err) kind = 3;
      if (kind == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int kind, nreq;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!mreq && !xv && !halt && !idl && !err && !cur_we, "R10 reset outputs",
        {58'd0, mreq, xv, halt, idl, err, cur_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!mreq, "R10 no request after reset", 64'(mreq), 0);

    // R1: start ignored when idle or stopped
    put_desc(0, 1, 16, 1, 1, 0);
    run = 1; idle = 1; nreq = 0;
    @(negedge clk); cur_i = '0; tail_i = '0; start = 1;
    @(negedge clk); start = 0;
    repeat (20) begin @(negedge clk); if (mreq) nreq++; end
    run = 0; idle = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (20) begin @(negedge clk); if (mreq) nreq++; end
    chk(nreq == 0, "R1 start ignored", 64'(nreq), 0);
    chk(mem[7] == 0, "R1 status untouched", 64'(mem[7]), 0);
    run = 1;

    // main chain with stalls: 3 descriptors, one frame
    stall_en = 1;
    put_desc(1, 2, 100, 1, 0, 0);
    put_desc(2, 3, 200, 0, 0, 0);
    put_desc(3, 9, 50, 0, 1, 0);
    expect_xf(1, 100, 1, 0); expect_xf(2, 200, 0, 0); expect_xf(3, 50, 0, 1);
    run_walk(1, 3, kind);
    chk(kind == 2, "R8 chain ends idle", 64'(kind), 2);
    chk(xq.size() == 0, "R4 all transfers seen", 64'(xq.size()), 0);
    chk(mem[23] == 32'h8000_0064, "R7 status d1", 64'(mem[23]), 64'h8000_0064);
    chk(mem[39] == 32'h8000_00C8, "R7 status d2", 64'(mem[39]), 64'h8000_00C8);
    chk(mem[55] == 32'h8000_0032, "R7 status d3", 64'(mem[55]), 64'h8000_0032);
    chk(last_cur == AW'(9*64), "R8 final pointer", 64'(last_cur), 9*64);
    stall_en = 0;

    // halt on an already completed descriptor
    put_desc(4, 5, 8, 1, 1, 0);
    put_desc(5, 6, 8, 1, 1, 1);
    expect_xf(4, 8, 1, 1);
    run_walk(4, 5, kind);
    chk(kind == 1, "R3 halt", 64'(kind), 1);
    chk(xq.size() == 0, "R3 no extra xfer", 64'(xq.size()), 0);
    chk(mem[87] == 32'h8000_0005, "R3 no write-back", 64'(mem[87]), 64'h8000_0005);
    chk(mem[71] == 32'h8000_0008, "R7 status d4", 64'(mem[71]), 64'h8000_0008);
    chk(last_cur == AW'(5*64), "R8 pointer at halted desc", 64'(last_cur), 5*64);

    // overflow: 10000 + 6385 > 16384
    put_desc(6, 7, 10000, 1, 0, 0);
    put_desc(7, 8, 6385, 0, 1, 0);
    expect_xf(6, 10000, 1, 0);
    run_walk(6, 7, kind);
    chk(kind == 3, "R9 overflow error", 64'(kind), 3);
    chk(xq.size() == 0, "R9 no xfer on overflow", 64'(xq.size()), 0);
    chk(mem[119] == 0, "R9 no write-back", 64'(mem[119]), 0);
    chk(last_cur == AW'(7*64), "R9 pointer not advanced", 64'(last_cur), 7*64);

    // boundary: exactly MAX_FRAME accepted
    put_desc(6, 7, 10000, 1, 0, 0);
    put_desc(7, 8, 6384, 0, 1, 0);
    expect_xf(6, 10000, 1, 0); expect_xf(7, 6384, 0, 1);
    run_walk(6, 7, kind);
    chk(kind == 2, "R9 exact limit accepted", 64'(kind), 2);
    chk(mem[119] == 32'h8000_18F0, "R7 status at limit", 64'(mem[119]), 64'h8000_18F0);
    chk(last_cur == AW'(8*64), "R8 pointer after limit", 64'(last_cur), 8*64);

    chk(r2_viol == 0, "R2 request held stable", 64'(r2_viol), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule